// File: doc/BRIEF.md
# Order-g maximum / minimum selector

The block receives a list of K unsigned N-bit values in parallel, together with a rank g and a direction bit. It returns the g-th largest value of the list, or the g-th smallest value when the direction bit is set. It also returns the position of an element that holds that value. Equal values are separate entries in the ranking. If the two largest entries are both 12, ranks 1 and 2 both give 12.

The block does not sort and does not use a comparator tree. It compares every input against every possible level 0..2^N-1, which gives each input a thermometer code. For each level it then decides whether at least g inputs reach that level. The answer is the highest level where that holds. A select stage turns those per-level decisions into the result. The select stage is either a linear chain with 2^N steps or a binary descent with N steps. Minimum search uses the same hardware on bit-inverted inputs and inverts the answer.

A parameter chooses between two configurations. The combinational one gives the result in the cycle the list arrives. The pipelined one puts registers after the comparison stage and after the counting stage. It accepts a new list on every cycle and has no stall.

Top module: `ostat_select`

## Requirements
- R1: In maximum mode (`in_min`=0), a valid list with rank g in 1..K yields the g-th largest entry. Duplicates count as separate entries.
- R2: In minimum mode (`in_min`=1), a valid list with rank g in 1..K yields the g-th smallest entry. Duplicates count separately.
- R3: Rank 1 in maximum mode gives the largest entry. Rank K in maximum mode gives the smallest entry. The mirrored statements hold in minimum mode.
- R4: `out_index` is the lowest position p whose entry equals `out_data`. Entry p occupies bits `in_data[p*N +: N]`.
- R5: A rank of 0 or above K still produces a valid result, but with `out_error`=1, `out_data`=0 and `out_index`=0.
- R6: With `PIPELINE`=1, `out_valid` and the result appear exactly 2 cycles after the list is presented. A new list is accepted every cycle, including back-to-back lists and lists separated by idle cycles.
- R7: While `rst_n` is low, `out_valid` is 0.
- R8: The chain select variant and the descent select variant give identical results for every input.
- R9: With `PIPELINE`=0, the result and `out_valid` follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | List present this cycle |
| in_data | input | K*N | K packed unsigned entries, entry p at bits p*N+N-1..p*N |
| in_rank | input | $clog2(K+1) | Rank g, legal range 1..K |
| in_min | input | 1 | 1 selects g-th smallest, 0 selects g-th largest |
| out_valid | output | 1 | Result present |
| out_data | output | N | Selected value, 0 on error |
| out_index | output | $clog2(K) | Lowest position holding the selected value |
| out_error | output | 1 | Rank was 0 or greater than K |

## Verification
Three test lists target duplicates. One has tied top entries, which separates "count entries" from "count distinct values". One has a value repeated at scattered positions, which checks the lowest-index rule. One list is all equal, which exercises every rank returning the same value. Extreme ranks 1 and K, applied in both directions, expose off-by-one errors in the per-level count compare. Ranks 0 and K+1 drive the error path. Long runs of random lists, back-to-back and with idle gaps, run on the pipelined descent instance, the pipelined chain instance and the combinational instance together. These runs separate a latency slip from a select-stage mismatch.

// File: rtl/ostat_pkg.sv
package ostat_pkg;
   typedef enum logic {
      MUX_CHAIN = 1'b0,
      MUX_TREE  = 1'b1
   } mux_style_e;
endpackage

// File: rtl/ostat_thermo.sv
module ostat_thermo #(
   parameter int K = 8,
   parameter int N = 4,
   localparam int LEVELS = 1 << N
)(
   input  logic [K*N-1:0]             vals,
   output logic [K-1:0][LEVELS-1:0]   therm
);
   // one comparator per (entry, level): bit set when entry reaches the level
   for (genvar i = 0; i < K; i++) begin : g_entry
      for (genvar j = 0; j < LEVELS; j++) begin : g_level
         assign therm[i][j] = (vals[i*N +: N] >= N'(j));
      end
   end
endmodule

// File: rtl/ostat_rank.sv
module ostat_rank #(
   parameter int K = 8,
   parameter int N = 4,
   localparam int LEVELS = 1 << N,
   localparam int GW     = $clog2(K + 1)
)(
   input  logic [K-1:0][LEVELS-1:0] therm,
   input  logic [GW-1:0]            rank,
   output logic [LEVELS-1:0]        sel
);
   for (genvar j = 0; j < LEVELS; j++) begin : g_level
      logic [GW-1:0] cnt;
      logic          pair;
      logic          later;

      // population count of entries at or above level j
      always_comb begin
         cnt = '0;
         for (int i = 0; i < K; i++) cnt = cnt + GW'(therm[i][j]);
      end

      // rank-2 fast term: each entry ANDed with the OR of all later entries
      always_comb begin
         pair  = 1'b0;
         later = 1'b0;
         for (int i = K - 1; i >= 0; i--) begin
            pair  = pair | (therm[i][j] & later);
            later = later | therm[i][j];
         end
      end

      assign sel[j] = (rank == GW'(2)) ? pair : (cnt >= rank);
   end
endmodule

// File: rtl/ostat_pick.sv
module ostat_pick import ostat_pkg::*; #(
   parameter int         N     = 4,
   parameter mux_style_e STYLE = MUX_TREE,
   localparam int LEVELS = 1 << N
)(
   input  logic [LEVELS-1:0] sel,
   output logic [N-1:0]      level
);
   if (STYLE == MUX_CHAIN) begin : g_chain
      // linear chain: each stage offers its own level when its select is high
      always_comb begin
         level = '0;
         for (int j = 1; j < LEVELS; j++) begin
            if (sel[j]) level = N'(j);
         end
      end
   end else begin : g_tree
      // select bits are monotone in level, so resolve one result bit per stage
      logic [N-1:0] cand;
      always_comb begin
         level = '0;
         cand  = '0;
         for (int b = N - 1; b >= 0; b--) begin
            cand = level | (N'(1) << b);
            if (sel[cand]) level = cand;
         end
      end
   end
endmodule

// File: rtl/ostat_select.sv
module ostat_select import ostat_pkg::*; #(
   parameter int         K         = 8,
   parameter int         N         = 4,
   parameter bit         PIPELINE  = 1'b1,
   parameter mux_style_e MUX_STYLE = MUX_TREE,
   localparam int LEVELS = 1 << N,
   localparam int GW     = $clog2(K + 1),
   localparam int IW     = $clog2(K)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [K*N-1:0]  in_data,
   input  logic [GW-1:0]   in_rank,
   input  logic            in_min,
   output logic            out_valid,
   output logic [N-1:0]    out_data,
   output logic [IW-1:0]   out_index,
   output logic            out_error
);
   if (K < 2) begin : g_bad_k
      $error("ostat_select: K must be at least 2");
   end
   if (N < 1 || N > 10) begin : g_bad_n
      $error("ostat_select: N must lie in 1..10");
   end

   // ---------------- stage A: transform and compare ----------------
   logic [K*N-1:0]            a_x;
   logic                      a_err;
   logic [K-1:0][LEVELS-1:0]  a_therm;

   assign a_x   = in_min ? ~in_data : in_data;
   assign a_err = (in_rank == '0) || (in_rank > GW'(K));

   ostat_thermo #(.K(K), .N(N)) u_thermo (
      .vals  (a_x),
      .therm (a_therm)
   );

   // ---------------- stage B: per-level counting ----------------
   logic [K-1:0][LEVELS-1:0]  b_therm;
   logic [GW-1:0]             b_rank;
   logic [K*N-1:0]            b_x;
   logic                      b_min, b_err, b_valid;
   logic [LEVELS-1:0]         b_sel;

   ostat_rank #(.K(K), .N(N)) u_rank (
      .therm (b_therm),
      .rank  (b_rank),
      .sel   (b_sel)
   );

   // ---------------- stage C: level selection ----------------
   logic [LEVELS-1:0]         c_sel;
   logic [K*N-1:0]            c_x;
   logic                      c_min, c_err, c_valid;
   logic [N-1:0]              c_level;

   if (PIPELINE) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            b_therm <= '0;
            b_rank  <= '0;
            b_x     <= '0;
            b_min   <= 1'b0;
            b_err   <= 1'b0;
            b_valid <= 1'b0;
            c_sel   <= '0;
            c_x     <= '0;
            c_min   <= 1'b0;
            c_err   <= 1'b0;
            c_valid <= 1'b0;
         end else begin
            b_therm <= a_therm;
            b_rank  <= in_rank;
            b_x     <= a_x;
            b_min   <= in_min;
            b_err   <= a_err;
            b_valid <= in_valid;
            c_sel   <= b_sel;
            c_x     <= b_x;
            c_min   <= b_min;
            c_err   <= b_err;
            c_valid <= b_valid;
         end
      end
   end else begin : g_comb
      assign b_therm = a_therm;
      assign b_rank  = in_rank;
      assign b_x     = a_x;
      assign b_min   = in_min;
      assign b_err   = a_err;
      assign b_valid = in_valid;
      assign c_sel   = b_sel;
      assign c_x     = b_x;
      assign c_min   = b_min;
      assign c_err   = b_err;
      assign c_valid = b_valid;
   end

   ostat_pick #(.N(N), .STYLE(MUX_STYLE)) u_pick (
      .sel   (c_sel),
      .level (c_level)
   );

   // lowest position holding the chosen level (same transformed domain)
   logic [IW-1:0] c_idx;
   logic          c_found;
   always_comb begin
      c_idx   = '0;
      c_found = 1'b0;
      for (int i = 0; i < K; i++) begin
         if (!c_found && (c_x[i*N +: N] == c_level)) begin
            c_idx   = IW'(i);
            c_found = 1'b1;
         end
      end
   end

   assign out_valid = c_valid;
   assign out_error = c_err;
   assign out_data  = c_err ? '0 : (c_level ^ {N{c_min}});
   assign out_index = c_err ? '0 : c_idx;
endmodule

// File: rtl/ostat_checker.sv
module ostat_checker #(
   parameter int K   = 8,
   parameter int N   = 4,
   parameter int GW  = 4,
   parameter int IW  = 3,
   parameter int LAT = 2
)(
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [GW-1:0] in_rank,
   input logic          out_valid,
   input logic          out_error,
   input logic [N-1:0]  out_data,
   input logic [IW-1:0] out_index
);
   if (LAT == 2) begin : g_lat2
      assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == $past(in_valid, 2));
      assert_errflag_R5: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (out_error == (($past(in_rank, 2) == '0) ||
                                      (int'($past(in_rank, 2)) > K))));
   end else begin : g_lat0
      assert_same_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid);
      assert_errflag_R5: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (out_error == ((in_rank == '0) || (int'(in_rank) > K))));
   end

   assert_error_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_error) |-> (out_data == '0 && out_index == '0));

   assert_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_index) < K));
endmodule

bind ostat_select ostat_checker #(
   .K(K), .N(N), .GW(GW), .IW(IW), .LAT(PIPELINE ? 2 : 0)
) u_ostat_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_rank   (in_rank),
   .out_valid (out_valid),
   .out_error (out_error),
   .out_data  (out_data),
   .out_index (out_index)
);

// File: tb/test_ostat_select.sv
`timescale 1ns/1ps
module test_ostat_select;
   import ostat_pkg::*;
   localparam int K  = 8;
   localparam int N  = 4;
   localparam int GW = $clog2(K + 1);
   localparam int IW = $clog2(K);

   typedef struct {
      bit    v;
      bit    err;
      int    data;
      int    idx;
      string tag;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [K*N-1:0]  in_data = '0;
   logic [GW-1:0]   in_rank = '0;
   logic            in_min = 1'b0;

   logic            t_valid, c_valid, z_valid;
   logic [N-1:0]    t_data, c_data, z_data;
   logic [IW-1:0]   t_index, c_index, z_index;
   logic            t_error, c_error, z_error;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   ostat_select #(.K(K), .N(N), .PIPELINE(1'b1), .MUX_STYLE(MUX_TREE)) i_ostat_select (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_rank(in_rank), .in_min(in_min), .out_valid(t_valid), .out_data(t_data),
      .out_index(t_index), .out_error(t_error));

   ostat_select #(.K(K), .N(N), .PIPELINE(1'b1), .MUX_STYLE(MUX_CHAIN)) i_ostat_select_chain (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_rank(in_rank), .in_min(in_min), .out_valid(c_valid), .out_data(c_data),
      .out_index(c_index), .out_error(c_error));

   ostat_select #(.K(K), .N(N), .PIPELINE(1'b0), .MUX_STYLE(MUX_CHAIN)) i_ostat_select_comb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_rank(in_rank), .in_min(in_min), .out_valid(z_valid), .out_data(z_data),
      .out_index(z_index), .out_error(z_error));

   exp_t cur, prev1;

   function automatic exp_t model(input bit v, input logic [K*N-1:0] d,
                                  input int g, input bit mn, input string tag);
      exp_t e;
      int   a[K];
      e.v = v; e.err = 1'b0; e.data = 0; e.idx = 0; e.tag = tag;
      if (!v) return e;
      if (g < 1 || g > K) begin
         e.err = 1'b1;
         return e;
      end
      for (int i = 0; i < K; i++) a[i] = int'(d[i*N +: N]);
      for (int i = 0; i < K; i++) begin
         for (int j = 0; j < K - 1 - i; j++) begin
            if (mn ? (a[j] > a[j+1]) : (a[j] < a[j+1])) begin
               int t = a[j]; a[j] = a[j+1]; a[j+1] = t;
            end
         end
      end
      e.data = a[g-1];
      for (int i = K - 1; i >= 0; i--) begin
         if (int'(d[i*N +: N]) == e.data) e.idx = i;
      end
      return e;
   endfunction

   task automatic chk(input string nm, input logic ov, input logic oe,
                      input logic [N-1:0] od, input logic [IW-1:0] oi,
                      input exp_t e, input string xr);
      checks++;
      if (ov !== e.v) begin
         failures++;
         $display("FAIL R6%s %s valid act=%b exp=%b", xr, nm, ov, e.v);
      end else if (e.v && (oe !== e.err || int'(od) != e.data || int'(oi) != e.idx)) begin
         failures++;
         $display("FAIL %s%s %s act err=%b data=%0d idx=%0d exp err=%b data=%0d idx=%0d",
                  e.tag, xr, nm, oe, od, oi, e.err, e.data, e.idx);
      end
   endtask

   // one cycle: check outputs, then present a new list
   task automatic step(input bit v, input logic [K*N-1:0] d, input int g,
                       input bit mn, input string tag);
      @(negedge clk);
      chk("comb",  z_valid, z_error, z_data, z_index, cur,   "/R9");
      chk("tree",  t_valid, t_error, t_data, t_index, prev1, "");
      chk("chain", c_valid, c_error, c_data, c_index, prev1, "/R8");
      prev1 = cur;
      cur   = model(v, d, g, mn, tag);
      in_valid = v;
      in_data  = d;
      in_rank  = GW'(g);
      in_min   = mn;
   endtask

   function automatic logic [K*N-1:0] pack(input int a[K]);
      logic [K*N-1:0] r;
      for (int i = 0; i < K; i++) r[i*N +: N] = N'(a[i]);
      return r;
   endfunction

   initial begin
      repeat (400000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int a[K];
      logic [K*N-1:0] d;
      cur = model(0, '0, 0, 0, "R7");
      prev1 = cur;
      // R7: outputs idle under reset
      repeat (3) begin
         @(negedge clk);
         checks++;
         if (t_valid !== 1'b0 || c_valid !== 1'b0) begin
            failures++;
            $display("FAIL R7 valid under reset act=%b/%b exp=0", t_valid, c_valid);
         end
      end
      rst_n = 1'b1;

      // R1: tied top entries counted separately
      a = '{3, 12, 7, 12, 0, 5, 9, 1}; d = pack(a);
      step(1, d, 1, 0, "R1");
      step(1, d, 2, 0, "R1");
      step(1, d, 3, 0, "R1");
      step(1, d, 4, 0, "R1");
      // R3: extreme ranks in both directions
      step(1, d, K, 0, "R3");
      step(1, d, 1, 1, "R3");
      step(1, d, K, 1, "R3");
      // R2: minimum mode with duplicated minimum
      a = '{6, 2, 15, 2, 8, 2, 11, 4}; d = pack(a);
      step(1, d, 1, 1, "R2");
      step(1, d, 3, 1, "R2");
      step(1, d, 4, 1, "R2");
      step(1, d, 6, 1, "R2");
      // R4: repeated value at scattered positions, lowest index wins
      a = '{1, 9, 4, 9, 13, 9, 0, 9}; d = pack(a);
      step(1, d, 2, 0, "R4");
      step(1, d, 5, 0, "R4");
      step(1, d, 4, 1, "R4");
      // R3: all equal, every rank gives the same value at index 0
      a = '{10, 10, 10, 10, 10, 10, 10, 10}; d = pack(a);
      for (int g = 1; g <= K; g++) step(1, d, g, g[0], "R3");
      // R3: full-scale values
      a = '{15, 0, 15, 0, 15, 0, 15, 0}; d = pack(a);
      step(1, d, 4, 0, "R3");
      step(1, d, 5, 0, "R3");
      // R5: illegal ranks
      step(1, d, 0, 0, "R5");
      step(1, d, K + 1, 1, "R5");
      step(1, d, 15, 0, "R5");
      // R6: idle gap then back-to-back random lists
      step(0, d, 3, 0, "R6");
      step(0, d, 3, 0, "R6");
      for (int n = 0; n < 400; n++) begin
         for (int i = 0; i < K; i++) a[i] = int'($urandom_range(0, 15));
         if (n % 3 == 0) a[$urandom_range(0, K-1)] = a[0];
         step(1, pack(a), int'($urandom_range(1, K)), bit'($urandom_range(0, 1)),
              (n % 2 == 0) ? "R1" : "R2");
      end
      // R6: random lists with idle gaps, including some illegal ranks
      for (int n = 0; n < 300; n++) begin
         for (int i = 0; i < K; i++) a[i] = int'($urandom_range(0, 15));
         step(bit'($urandom_range(0, 1)), pack(a), int'($urandom_range(0, K + 1)),
              bit'($urandom_range(0, 1)), "R6");
      end
      step(0, '0, 1, 0, "R6");
      step(0, '0, 1, 0, "R6");
      step(0, '0, 1, 0, "R6");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule